// File: doc/BRIEF.md
# Pipeline Hazard Detection Unit

This block is the stall and flush controller for a five-stage, in-order integer pipeline in which branches and register jumps are resolved in the decode stage. Each cycle it looks at the source registers that the decode-stage instruction actually reads and at the destinations that the execute-stage and memory-stage instructions will write. From these it decides whether the front of the pipeline must freeze while a bubble goes into execute, or whether the single wrongly fetched instruction behind a taken control transfer must be discarded.

Since targets and branch outcomes are formed in decode, a taken transfer costs one cycle: only the fetch/decode pipeline register is cleared. The price is that a control instruction needs its operands one stage earlier than an ordinary ALU instruction. It must therefore wait behind an ALU result still in execute, and behind a load in either execute or memory. An ordinary consumer waits only for a load in execute.

The block is purely combinational. Its outputs respond in the same cycle to the pipeline state presented at its inputs. The surrounding pipeline registers, the forwarding network, the register file and the comparator live elsewhere.

Top module: `hzd_unit`

## Requirements
- R1: When the execute-stage instruction is a load with write enable high and a nonzero destination equal to a used decode source (first or second), the unit stalls in that cycle.
- R2: A stall drives pc_we low, ifid_hold high and idex_bubble high together. With no stall, pc_we is high and the other two are low.
- R3: A decode redirect (id_redirect high) in a cycle with no stall raises ifid_flush for that cycle only. ifid_flush is low whenever id_redirect is low.
- R4: A control instruction in decode (id_is_ctrl high) whose used source matches the write-enabled, nonzero destination of a non-load in execute stalls for one cycle.
- R5: A control instruction in decode whose used source matches a write-enabled, nonzero load destination in memory stalls. A load in execute feeding a branch therefore costs two stall cycles. A non-control consumer of a memory-stage load does not stall, and neither does any consumer of a non-load in memory.
- R6: Register index 0 never causes a stall, whether as a source or as a destination.
- R7: A producer whose write enable is low never causes a stall, even if it is flagged as a load.
- R8: A source whose usage flag is low never causes a stall, whatever its index field holds.
- R9: A stall has priority over a flush. While stalling, ifid_flush stays low even with id_redirect high, and the flush occurs in the first cycle without a stall.
- R10: A non-control decode instruction that reads the destination of a non-load in execute does not stall, because forwarding supplies the value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| id_rs1 | input | 5 | First source register index of the decode instruction |
| id_rs1_used | input | 1 | First source is actually read |
| id_rs2 | input | 5 | Second source register index of the decode instruction |
| id_rs2_used | input | 1 | Second source is actually read |
| id_is_ctrl | input | 1 | Decode instruction is a branch or register jump that needs its operands in decode |
| id_redirect | input | 1 | Decode has resolved a taken branch or jump |
| ex_rd | input | 5 | Destination index of the execute-stage instruction |
| ex_rd_we | input | 1 | Execute-stage instruction writes a register |
| ex_is_load | input | 1 | Execute-stage instruction is a load |
| mem_rd | input | 5 | Destination index of the memory-stage instruction |
| mem_rd_we | input | 1 | Memory-stage instruction writes a register |
| mem_is_load | input | 1 | Memory-stage instruction is a load |
| pc_we | output | 1 | Program counter may advance |
| ifid_hold | output | 1 | Keep the fetch/decode register unchanged |
| idex_bubble | output | 1 | Load a NOP into the decode/execute register |
| ifid_flush | output | 1 | Clear the fetch/decode register to a NOP |

## Verification
The checker tests invariants on every input combination as it occurs. The three stall outputs always move as one group, a flush never coincides with a stall, a flush never appears without a redirect and always follows an unstalled redirect, an execute-stage load hit always stalls, and unused or zero sources and disabled writers never stall. Only the bench's scenarios can show the stage-dependent behaviour: which producer kinds stall which consumer kinds, that forwardable cases pass freely, and how a load feeding a taken branch plays out over time, with two stalled cycles followed by a single flush.

// File: rtl/hzd_pkg.sv
package hzd_pkg;

    parameter int unsigned REG_IDX_W = 5;
    parameter int unsigned NUM_SRC   = 2;
    parameter int unsigned NUM_PROD  = 2;

    localparam int unsigned PROD_EX  = 0;
    localparam int unsigned PROD_MEM = 1;

    typedef logic [REG_IDX_W-1:0] reg_idx_t;

    typedef struct packed {
        reg_idx_t idx;
        logic     used;
    } src_t;

    typedef struct packed {
        reg_idx_t idx;
        logic     we;
        logic     is_load;
    } prod_t;

    typedef struct packed {
        logic pc_we;
        logic ifid_hold;
        logic idex_bubble;
        logic ifid_flush;
    } ctl_t;

endpackage

// File: rtl/hzd_src_cmp.sv
module hzd_src_cmp
    import hzd_pkg::*;
(
    input  src_t  src,
    input  prod_t prod,
    output logic  hit
);
    logic idx_eq_d;
    logic idx_nz_d;

    always_comb begin
        idx_eq_d = (src.idx == prod.idx);
        idx_nz_d = (src.idx != '0);
        hit      = src.used && prod.we && idx_nz_d && idx_eq_d;
    end
endmodule

// File: rtl/hzd_resolve.sv
module hzd_resolve
    import hzd_pkg::*;
(
    input  logic [NUM_SRC-1:0] ex_hit,
    input  logic [NUM_SRC-1:0] mem_hit,
    input  logic               ex_is_load,
    input  logic               mem_is_load,
    input  logic               is_ctrl,
    input  logic               redirect,
    output ctl_t               ctl
);
    logic any_ex_d;
    logic any_mem_d;
    logic load_use_d;
    logic ctrl_ex_d;
    logic ctrl_mem_d;
    logic stall_d;
    ctl_t ctl_d;

    always_comb begin
        any_ex_d   = |ex_hit;
        any_mem_d  = |mem_hit;
        // ordinary consumer: only a load in execute is too late to forward
        load_use_d = any_ex_d && ex_is_load;
        // decode-stage consumer: any execute result is too late
        ctrl_ex_d  = any_ex_d && is_ctrl;
        // decode-stage consumer: load data still in memory stage
        ctrl_mem_d = any_mem_d && mem_is_load && is_ctrl;
        stall_d    = load_use_d || ctrl_ex_d || ctrl_mem_d;

        ctl_d.pc_we       = !stall_d;
        ctl_d.ifid_hold   = stall_d;
        ctl_d.idex_bubble = stall_d;
        // an unresolved branch must never redirect: stall wins
        ctl_d.ifid_flush  = redirect && !stall_d;
        ctl = ctl_d;
    end
endmodule

// File: rtl/hzd_unit.sv
module hzd_unit
    import hzd_pkg::*;
(
    input  logic [4:0] id_rs1,
    input  logic       id_rs1_used,
    input  logic [4:0] id_rs2,
    input  logic       id_rs2_used,
    input  logic       id_is_ctrl,
    input  logic       id_redirect,
    input  logic [4:0] ex_rd,
    input  logic       ex_rd_we,
    input  logic       ex_is_load,
    input  logic [4:0] mem_rd,
    input  logic       mem_rd_we,
    input  logic       mem_is_load,
    output logic       pc_we,
    output logic       ifid_hold,
    output logic       idex_bubble,
    output logic       ifid_flush
);
    src_t  src_d  [NUM_SRC];
    prod_t prod_d [NUM_PROD];
    logic [NUM_SRC-1:0] hit_d [NUM_PROD];
    ctl_t  ctl_d;

    always_comb begin
        src_d[0]  = '{idx: id_rs1, used: id_rs1_used};
        src_d[1]  = '{idx: id_rs2, used: id_rs2_used};
        prod_d[PROD_EX]  = '{idx: ex_rd,  we: ex_rd_we,  is_load: ex_is_load};
        prod_d[PROD_MEM] = '{idx: mem_rd, we: mem_rd_we, is_load: mem_is_load};
    end

    for (genvar p = 0; p < NUM_PROD; p++) begin : g_prod
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            hzd_src_cmp u_cmp (
                .src  (src_d[s]),
                .prod (prod_d[p]),
                .hit  (hit_d[p][s])
            );
        end
    end

    hzd_resolve u_resolve (
        .ex_hit      (hit_d[PROD_EX]),
        .mem_hit     (hit_d[PROD_MEM]),
        .ex_is_load  (prod_d[PROD_EX].is_load),
        .mem_is_load (prod_d[PROD_MEM].is_load),
        .is_ctrl     (id_is_ctrl),
        .redirect    (id_redirect),
        .ctl         (ctl_d)
    );

    assign pc_we       = ctl_d.pc_we;
    assign ifid_hold   = ctl_d.ifid_hold;
    assign idex_bubble = ctl_d.idex_bubble;
    assign ifid_flush  = ctl_d.ifid_flush;
endmodule

// File: rtl/hzd_unit_chk.sv
module hzd_unit_chk (
    input logic [4:0] id_rs1,
    input logic       id_rs1_used,
    input logic [4:0] id_rs2,
    input logic       id_rs2_used,
    input logic       id_redirect,
    input logic [4:0] ex_rd,
    input logic       ex_rd_we,
    input logic       ex_is_load,
    input logic       mem_rd_we,
    input logic       pc_we,
    input logic       ifid_hold,
    input logic       idex_bubble,
    input logic       ifid_flush
);
    logic src_quiet;
    logic ex_load_hit;

    always_comb begin
        src_quiet   = (!id_rs1_used || id_rs1 == '0) && (!id_rs2_used || id_rs2 == '0);
        ex_load_hit = ex_is_load && ex_rd_we && ex_rd != '0 &&
                      ((id_rs1_used && id_rs1 == ex_rd) || (id_rs2_used && id_rs2 == ex_rd));

        a_r2_stall_group: assert ((pc_we == !ifid_hold) && (ifid_hold == idex_bubble))
            else $error("stall outputs disagree");
        a_r9_no_flush_while_stall: assert (!(ifid_flush && ifid_hold))
            else $error("flush during stall");
        a_r3_flush_needs_redirect: assert (!ifid_flush || id_redirect)
            else $error("flush without redirect");
        a_r3_redirect_flushes: assert (!(id_redirect && !ifid_hold) || ifid_flush)
            else $error("unstalled redirect not flushed");
        a_r1_ex_load_stalls: assert (!ex_load_hit || ifid_hold)
            else $error("load-use not stalled");
        a_r6_r8_quiet_src: assert (!src_quiet || !ifid_hold)
            else $error("stall with no live source");
        a_r7_no_writer: assert (ex_rd_we || mem_rd_we || !ifid_hold)
            else $error("stall with no writer");
    end
endmodule

bind hzd_unit hzd_unit_chk u_chk (
    .id_rs1      (id_rs1),
    .id_rs1_used (id_rs1_used),
    .id_rs2      (id_rs2),
    .id_rs2_used (id_rs2_used),
    .id_redirect (id_redirect),
    .ex_rd       (ex_rd),
    .ex_rd_we    (ex_rd_we),
    .ex_is_load  (ex_is_load),
    .mem_rd_we   (mem_rd_we),
    .pc_we       (pc_we),
    .ifid_hold   (ifid_hold),
    .idex_bubble (idex_bubble),
    .ifid_flush  (ifid_flush)
);

// File: tb/hzd_unit_tb.sv
module hzd_unit_tb;

    typedef struct {
        logic  stall;
        logic  flush;
        string tag;
    } exp_t;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #10 clk = ~clk;

    logic [4:0] id_rs1 = '0, id_rs2 = '0, ex_rd = '0, mem_rd = '0;
    logic id_rs1_used = 1'b0, id_rs2_used = 1'b0, id_is_ctrl = 1'b0, id_redirect = 1'b0;
    logic ex_rd_we = 1'b0, ex_is_load = 1'b0, mem_rd_we = 1'b0, mem_is_load = 1'b0;
    logic pc_we, ifid_hold, idex_bubble, ifid_flush;

    int total = 0;
    int bad = 0;
    exp_t sb_q[$];

    hzd_unit u_dut (
        .id_rs1(id_rs1), .id_rs1_used(id_rs1_used),
        .id_rs2(id_rs2), .id_rs2_used(id_rs2_used),
        .id_is_ctrl(id_is_ctrl), .id_redirect(id_redirect),
        .ex_rd(ex_rd), .ex_rd_we(ex_rd_we), .ex_is_load(ex_is_load),
        .mem_rd(mem_rd), .mem_rd_we(mem_rd_we), .mem_is_load(mem_is_load),
        .pc_we(pc_we), .ifid_hold(ifid_hold),
        .idex_bubble(idex_bubble), .ifid_flush(ifid_flush)
    );

    // decode side: rs1, rs1 used, rs2, rs2 used, ctrl, redirect
    task automatic set_id(input logic [4:0] r1, input logic u1, input logic [4:0] r2,
                          input logic u2, input logic ctl, input logic rdr);
        id_rs1 = r1; id_rs1_used = u1; id_rs2 = r2; id_rs2_used = u2;
        id_is_ctrl = ctl; id_redirect = rdr;
    endtask

    task automatic set_prod(input logic [4:0] erd, input logic ewe, input logic eld,
                            input logic [4:0] mrd, input logic mwe, input logic mld);
        ex_rd = erd; ex_rd_we = ewe; ex_is_load = eld;
        mem_rd = mrd; mem_rd_we = mwe; mem_is_load = mld;
    endtask

    // driver: inputs already set by caller, publish expectation at negedge
    task automatic push(input logic st, input logic fl, input string tag);
        exp_t e;
        e.stall = st; e.flush = fl; e.tag = tag;
        sb_q.push_back(e);
    endtask

    task automatic cyc(input logic st, input logic fl, input string tag);
        push(st, fl, tag);
        @(negedge clk);
    endtask

    // monitor: compare 1 ns after each rising edge
    initial begin
        forever begin
            @(posedge clk);
            #1;
            if (!rst && sb_q.size() > 0) begin
                exp_t e;
                logic [3:0] act, exp;
                e = sb_q.pop_front();
                act = {pc_we, ifid_hold, idex_bubble, ifid_flush};
                exp = {!e.stall, e.stall, e.stall, e.flush};
                total++;
                if (act !== exp) begin
                    bad++;
                    $display("FAIL %s: {pc_we,hold,bubble,flush} actual=%b expected=%b",
                             e.tag, act, exp);
                end
            end
        end
    end

    initial begin
        repeat (5000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;

        set_id(0, 0, 0, 0, 0, 0); set_prod(0, 0, 0, 0, 0, 0);
        cyc(0, 0, "R2 idle state");

        set_id(5, 1, 0, 0, 0, 0); set_prod(5, 1, 1, 0, 0, 0);
        cyc(1, 0, "R1 load-use rs1");
        set_id(3, 1, 5, 1, 0, 0);
        cyc(1, 0, "R1 load-use rs2");
        set_id(3, 1, 5, 0, 0, 0);
        cyc(0, 0, "R8 rs2 unused no stall");
        set_id(5, 0, 5, 0, 1, 0);
        cyc(0, 0, "R8 ctrl both unused no stall");

        set_id(5, 1, 0, 0, 0, 0); set_prod(5, 1, 0, 0, 0, 0);
        cyc(0, 0, "R10 alu forwarded no stall");
        set_id(5, 1, 0, 0, 1, 0);
        cyc(1, 0, "R4 ctrl waits on ex alu");
        set_id(0, 0, 5, 1, 1, 1);
        cyc(1, 0, "R9 stall beats redirect");

        set_id(9, 1, 0, 0, 1, 0); set_prod(1, 1, 0, 9, 1, 1);
        cyc(1, 0, "R5 ctrl waits on mem load");
        set_id(9, 1, 0, 0, 0, 0);
        cyc(0, 0, "R5 plain consumer of mem load");
        set_id(9, 1, 0, 0, 1, 0); set_prod(1, 1, 0, 9, 1, 0);
        cyc(0, 0, "R5 ctrl with mem alu forwarded");

        set_id(0, 1, 0, 1, 1, 0); set_prod(0, 1, 1, 0, 1, 1);
        cyc(0, 0, "R6 x0 ignored");
        set_id(5, 1, 5, 1, 1, 0); set_prod(5, 0, 1, 5, 0, 1);
        cyc(0, 0, "R7 write enable low ignored");

        set_id(0, 0, 0, 0, 1, 1); set_prod(0, 0, 0, 0, 0, 0);
        cyc(0, 1, "R3 redirect flushes");
        set_id(0, 0, 0, 0, 0, 0);
        cyc(0, 0, "R3 flush one cycle only");

        // load x7 then taken branch reading x7: two stalls, then one flush
        set_id(7, 1, 2, 1, 1, 1); set_prod(7, 1, 1, 4, 1, 0);
        cyc(1, 0, "R5 load-branch stall one");
        set_prod(0, 0, 0, 7, 1, 1);
        cyc(1, 0, "R5 load-branch stall two");
        set_prod(0, 0, 0, 0, 0, 0);
        cyc(0, 1, "R9 flush after stall clears");
        set_id(0, 0, 0, 0, 0, 0);
        cyc(0, 0, "R2 back to idle");

        repeat (3) @(negedge clk);
        if (sb_q.size() != 0) begin
            total++; bad++;
            $display("FAIL scoreboard: actual=%0d left expected=0", sb_q.size());
        end
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule